// File: doc/BRIEF.md
# Two-Way Read-Allocate Cache Tag Controller

This block is the tag and state controller of a 16 KB two-way set-associative data cache that uses a writeback policy. Each CPU address is split into a line offset, a set index and a tag. The tag is compared against both ways of the indexed set. For every set the block keeps the valid and dirty bits of each way and a single least-recently-used bit. Read misses allocate a line. Write misses never allocate; they are forwarded to an external write buffer in the cycle the write is accepted. A write hit only marks the line dirty.

On a read miss the controller picks a victim way and latches it. It then requests the new line from lower memory and holds the CPU port until the fill completes. A dirty victim is written back only after the fill returns, and only if the fill reports the line as cacheable. A noncacheable fill installs nothing, cancels the writeback and leaves the victim resident. A maintenance operation walks a range of consecutive line addresses. It writes back dirty resident lines and then either cleans them or invalidates every resident line in the range. A maintenance request takes priority over a CPU access that arrives in the same cycle.

Top module: `dcache_tagctl`

## Requirements
- R1: An address is split as offset = bits 5:0, set index = bits 12:6 and tag = bits 31:13. The offset does not affect hit or miss. Fill requests carry the address with bits 5:0 cleared.
- R2: Two lines with different tags in the same set are resident at the same time. A line in another set is independent of them.
- R3: An access hits only when a valid way of the indexed set holds the same tag. After reset every way is invalid, so the first access misses. At most one way hits.
- R4: A write miss allocates nothing. It pulses `wbufValid` in the accepted cycle with `wbufAddr` equal to the full CPU address, starts no fill, and a later read of that line misses.
- R5: A read miss drops `cpuReady` and holds `fillReq` with the line address until `fillDone`. A cacheable fill installs the line, so a later read of it hits.
- R6: A write hit produces no write-buffer or lower-memory traffic and marks the line dirty, which shows up as a writeback when the line is later evicted.
- R7: The victim is an invalid way if there is one (way 0 before way 1). Otherwise it is the way least recently read or written. Hits and fills update the choice.
- R8: A dirty victim is written back after a cacheable `fillDone`. `vwbReq` is held with the victim's line address until `vwbDone`. A clean victim causes no writeback.
- R9: On a fill with `fillCacheable` = 0, nothing is installed, there is no victim writeback, and the victim line stays resident.
- R10: A maintenance operation with `opInval` = 1 over `opLines` lines from `opAddr` writes back each dirty resident line and invalidates every resident line in the range. Lines outside the range are untouched.
- R11: A maintenance operation with `opInval` = 0 writes back each dirty resident line and leaves it valid and clean.
- R12: While a miss or an operation is in progress, `cpuReady` is 0 and no CPU access is accepted: `cpuHit` and `wbufValid` stay 0.
- R13: When `opReq` and `cpuReq` arrive together, the operation wins and the CPU access is not accepted. An operation with `opLines` = 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU access request |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | CPU byte address |
| cpuReady | output | 1 | Controller idle; access accepted when cpuReq is high |
| cpuHit | output | 1 | Accepted access hits |
| wbufValid | output | 1 | Write miss forwarded to the write buffer |
| wbufAddr | output | 32 | Address of the forwarded write |
| fillReq | output | 1 | Line fetch request to lower memory |
| fillAddr | output | 32 | Line address to fetch |
| fillDone | input | 1 | Fill complete (one-cycle pulse) |
| fillCacheable | input | 1 | Fetched line may be cached, valid with fillDone |
| vwbReq | output | 1 | Line writeback request |
| vwbAddr | output | 32 | Line address being written back |
| vwbDone | input | 1 | Writeback complete (one-cycle pulse) |
| opReq | input | 1 | Start a range maintenance operation |
| opInval | input | 1 | 1 = writeback-invalidate, 0 = writeback only |
| opAddr | input | 32 | First address of the range |
| opLines | input | 8 | Number of consecutive lines in the range |

## Verification
The hardest case to reach from the ports is a noncacheable fill whose victim is dirty. This needs both ways of one set to be dirty and the LRU bit to point at a known way. The stimulus builds that state with a chosen order of write hits, returns `fillCacheable` = 0 for the miss, and then reads the victim back to show that it is still resident. A scoreboard queue holds every expected fill, writeback and write-buffer event in order. That queue shows each writeback following its fill, and it catches any missing or extra lower-memory traffic during stalls and maintenance walks.

// File: rtl/tagctl_pkg.sv
package tagctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_VWB,
    ST_SCAN,
    ST_OPWB
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic lookupOp;   // lookup port uses the operation cursor
    logic setDirty;   // write hit: mark hit way dirty
    logic touch;      // hit: move LRU away from hit way
    logic latchMiss;  // capture miss line and victim
    logic install;    // cacheable fill: write tag, valid, clean
    logic latchOp;    // capture operation range
    logic opAdvance;  // step operation cursor
    logic opClean;    // clear dirty of hit way
    logic opInval;    // clear valid of hit way
  } dpStrobe_t;

endpackage

// File: rtl/tagctl_dp.sv
module tagctl_dp
  import tagctl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         str,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [CNT_W-1:0]  opLines,
  output logic              lkHit,
  output logic              lkHitDirty,
  output logic              missVicDirty,
  output logic              opLast,
  output logic              opZero,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [ADDR_W-1:0] vwbMissAddr,
  output logic [ADDR_W-1:0] opCurAddr
);

  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int WAYS  = 2;
  localparam int unsigned STEP = 2 ** OFF_W;

  logic [ADDR_W-1:0] lkAddr;
  logic [TAG_W-1:0]  lkTag;
  logic [IDX_W-1:0]  lkIdx;

  logic [WAYS-1:0]  wayHit;
  logic [WAYS-1:0]  wayValid;
  logic [WAYS-1:0]  wayDirty;
  logic [TAG_W-1:0] wayTag [WAYS];
  logic             lkHitWay;
  logic             victimWay;

  logic [SETS-1:0]  lruBits;

  logic [TAG_W-1:0]  missTag;
  logic [IDX_W-1:0]  missIdx;
  logic              missVicWay;
  logic [TAG_W-1:0]  missVicTag;
  logic [ADDR_W-1:0] opCur;
  logic [CNT_W-1:0]  opRem;

  assign lkAddr = str.lookupOp ? opCur : cpuAddr;
  assign lkTag  = lkAddr[ADDR_W-1 -: TAG_W];
  assign lkIdx  = lkAddr[OFF_W +: IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vBits;
    logic [SETS-1:0]  dBits;
    logic [TAG_W-1:0] tagMem [SETS];

    assign wayValid[w] = vBits[lkIdx];
    assign wayDirty[w] = dBits[lkIdx];
    assign wayTag[w]   = tagMem[lkIdx];
    assign wayHit[w]   = vBits[lkIdx] && (tagMem[lkIdx] == lkTag);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vBits <= '0;
        dBits <= '0;
      end else begin
        if (str.setDirty && wayHit[w]) dBits[lkIdx] <= 1'b1;
        if (str.opClean && wayHit[w])  dBits[lkIdx] <= 1'b0;
        if (str.opInval && wayHit[w])  vBits[lkIdx] <= 1'b0;
        if (str.install && (missVicWay == 1'(w))) begin
          vBits[missIdx] <= 1'b1;
          dBits[missIdx] <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (str.install && (missVicWay == 1'(w))) tagMem[missIdx] <= missTag;
    end

    // a write hit leaves the hit line dirty
    assert_whit_dirty_R6 : assert property (@(posedge clk) disable iff (!rstN)
      (str.setDirty && wayHit[w]) |=> dBits[$past(lkIdx)]);
  end

  assign lkHit      = |wayHit;
  assign lkHitWay   = wayHit[1];
  assign lkHitDirty = |(wayHit & wayDirty);

  always_comb begin
    if (!wayValid[0])      victimWay = 1'b0;
    else if (!wayValid[1]) victimWay = 1'b1;
    else                   victimWay = lruBits[lkIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lruBits <= '0;
    end else begin
      if (str.touch)   lruBits[lkIdx]   <= ~lkHitWay;
      if (str.install) lruBits[missIdx] <= ~missVicWay;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missTag      <= '0;
      missIdx      <= '0;
      missVicWay   <= 1'b0;
      missVicTag   <= '0;
      missVicDirty <= 1'b0;
    end else if (str.latchMiss) begin
      missTag      <= lkTag;
      missIdx      <= lkIdx;
      missVicWay   <= victimWay;
      missVicTag   <= wayTag[victimWay];
      missVicDirty <= wayValid[victimWay] && wayDirty[victimWay];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opCur <= '0;
      opRem <= '0;
    end else if (str.latchOp) begin
      opCur <= {opAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      opRem <= opLines;
    end else if (str.opAdvance) begin
      opCur <= opCur + ADDR_W'(STEP);
      opRem <= opRem - CNT_W'(1);
    end
  end

  assign opLast      = (opRem == CNT_W'(1));
  assign opZero      = (opLines == '0);
  assign fillAddr    = {missTag, missIdx, {OFF_W{1'b0}}};
  assign vwbMissAddr = {missVicTag, missIdx, {OFF_W{1'b0}}};
  assign opCurAddr   = opCur;

  // never two ways holding the same line
  assert_single_hit_R3 : assert property (@(posedge clk) disable iff (!rstN)
    $countones(wayHit) <= 1);

endmodule

// File: rtl/tagctl_fsm.sv
module tagctl_fsm
  import tagctl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      cpuWe,
  input  logic      opReq,
  input  logic      opInval,
  input  logic      lkHit,
  input  logic      lkHitDirty,
  input  logic      missVicDirty,
  input  logic      opLast,
  input  logic      opZero,
  input  logic      fillDone,
  input  logic      fillCacheable,
  input  logic      vwbDone,
  output dpStrobe_t str,
  output logic      cpuReady,
  output logic      cpuHit,
  output logic      wbufValid,
  output logic      fillReq,
  output logic      vwbReq,
  output logic      vwbFromOp
);

  ctlState_t state, stateNext;
  logic      invMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      invMode <= 1'b0;
    end else begin
      state <= stateNext;
      if (str.latchOp) invMode <= opInval;
    end
  end

  always_comb begin
    str       = '0;
    stateNext = state;
    cpuReady  = 1'b0;
    cpuHit    = 1'b0;
    wbufValid = 1'b0;
    fillReq   = 1'b0;
    vwbReq    = 1'b0;
    vwbFromOp = 1'b0;
    str.lookupOp = (state == ST_SCAN) || (state == ST_OPWB);
    case (state)
      ST_IDLE: begin
        cpuReady = 1'b1;
        if (opReq) begin
          str.latchOp = 1'b1;
          if (!opZero) stateNext = ST_SCAN;
        end else if (cpuReq) begin
          if (lkHit) begin
            cpuHit       = 1'b1;
            str.touch    = 1'b1;
            str.setDirty = cpuWe;
          end else if (cpuWe) begin
            wbufValid = 1'b1;
          end else begin
            str.latchMiss = 1'b1;
            stateNext     = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        fillReq = 1'b1;
        if (fillDone) begin
          if (fillCacheable) begin
            str.install = 1'b1;
            stateNext   = missVicDirty ? ST_VWB : ST_IDLE;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_VWB: begin
        vwbReq = 1'b1;
        if (vwbDone) stateNext = ST_IDLE;
      end
      ST_SCAN: begin
        if (lkHit && lkHitDirty) begin
          stateNext = ST_OPWB;
        end else begin
          str.opInval   = lkHit && invMode;
          str.opAdvance = 1'b1;
          stateNext     = opLast ? ST_IDLE : ST_SCAN;
        end
      end
      ST_OPWB: begin
        vwbReq    = 1'b1;
        vwbFromOp = 1'b1;
        if (vwbDone) begin
          str.opClean   = 1'b1;
          str.opInval   = invMode;
          str.opAdvance = 1'b1;
          stateNext     = opLast ? ST_IDLE : ST_SCAN;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assert_wmiss_no_fill_R4 : assert property (@(posedge clk) disable iff (!rstN)
    wbufValid |=> !fillReq);

  assert_fill_held_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !fillDone) |=> fillReq);

  assert_wb_after_fill_R8 : assert property (@(posedge clk) disable iff (!rstN)
    ($rose(vwbReq) && !vwbFromOp) |-> $past(fillDone && fillCacheable));

  assert_nc_no_wb_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && fillDone && !fillCacheable) |=> !vwbReq);

endmodule

// File: rtl/dcache_tagctl.sv
module dcache_tagctl
  import tagctl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuReady,
  output logic              cpuHit,
  output logic              wbufValid,
  output logic [ADDR_W-1:0] wbufAddr,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillDone,
  input  logic              fillCacheable,
  output logic              vwbReq,
  output logic [ADDR_W-1:0] vwbAddr,
  input  logic              vwbDone,
  input  logic              opReq,
  input  logic              opInval,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [CNT_W-1:0]  opLines
);

  dpStrobe_t         str;
  logic              lkHit, lkHitDirty, missVicDirty, opLast, opZero, vwbFromOp;
  logic [ADDR_W-1:0] vwbMissAddr, opCurAddr;

  tagctl_dp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .cpuAddr(cpuAddr), .opAddr(opAddr),
    .opLines(opLines), .lkHit(lkHit), .lkHitDirty(lkHitDirty),
    .missVicDirty(missVicDirty), .opLast(opLast), .opZero(opZero),
    .fillAddr(fillAddr), .vwbMissAddr(vwbMissAddr), .opCurAddr(opCurAddr)
  );

  tagctl_fsm u_fsm (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .opReq(opReq),
    .opInval(opInval), .lkHit(lkHit), .lkHitDirty(lkHitDirty),
    .missVicDirty(missVicDirty), .opLast(opLast), .opZero(opZero),
    .fillDone(fillDone), .fillCacheable(fillCacheable), .vwbDone(vwbDone),
    .str(str), .cpuReady(cpuReady), .cpuHit(cpuHit), .wbufValid(wbufValid),
    .fillReq(fillReq), .vwbReq(vwbReq), .vwbFromOp(vwbFromOp)
  );

  assign wbufAddr = cpuAddr;
  assign vwbAddr  = vwbFromOp ? opCurAddr : vwbMissAddr;

endmodule

// File: tb/tb_dcache_tagctl.sv
module tb_dcache_tagctl;

  localparam int EV_WBUF = 0;
  localparam int EV_FILL = 1;
  localparam int EV_VWB  = 2;

  typedef struct {
    int          kind;
    logic [31:0] addr;
  } ev_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic        cpuReady, cpuHit, wbufValid, fillReq, vwbReq;
  logic [31:0] wbufAddr, fillAddr, vwbAddr;
  logic        fillDone = 1'b0, fillCacheable;
  logic        vwbDone = 1'b0;
  logic        opReq = 1'b0, opInval = 1'b0;
  logic [31:0] opAddr = '0;
  logic [7:0]  opLines = '0;

  logic nextCacheable = 1'b1;
  int   fillDelay = 2;
  int   nCmp = 0;
  int   nBad = 0;
  ev_t  expQ[$];

  assign fillCacheable = nextCacheable;

  always #10 clk = ~clk;

  dcache_tagctl dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuReady(cpuReady), .cpuHit(cpuHit), .wbufValid(wbufValid), .wbufAddr(wbufAddr),
    .fillReq(fillReq), .fillAddr(fillAddr), .fillDone(fillDone),
    .fillCacheable(fillCacheable), .vwbReq(vwbReq), .vwbAddr(vwbAddr),
    .vwbDone(vwbDone), .opReq(opReq), .opInval(opInval), .opAddr(opAddr),
    .opLines(opLines)
  );

  function automatic logic [31:0] mk(int t, int i);
    return (32'(t) << 13) | (32'(i) << 6);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_ev(int kind, logic [31:0] addr);
    ev_t e;
    e.kind = kind;
    e.addr = addr;
    expQ.push_back(e);
  endtask

  task automatic popCmp(int kind, logic [31:0] addr);
    ev_t e;
    nCmp++;
    if (expQ.size() == 0) begin
      nBad++;
      $display("FAIL R4 R5 R8 R10 R11 unexpected event actual=%0d:%h expected=none", kind, addr);
    end else begin
      e = expQ.pop_front();
      if (e.kind != kind || e.addr !== addr) begin
        nBad++;
        $display("FAIL R4 R5 R8 R10 R11 event actual=%0d:%h expected=%0d:%h",
                 kind, addr, e.kind, e.addr);
      end
    end
  endtask

  // lower memory responder
  initial begin
    int fillCnt = 0;
    int vwbCnt = 0;
    forever begin
      @(negedge clk); #1;
      if (fillDone) fillDone = 1'b0;
      else if (fillReq) begin
        fillCnt++;
        if (fillCnt >= fillDelay) begin fillDone = 1'b1; fillCnt = 0; end
      end
      if (vwbDone) vwbDone = 1'b0;
      else if (vwbReq) begin
        vwbCnt++;
        if (vwbCnt >= 2) begin vwbDone = 1'b1; vwbCnt = 0; end
      end
    end
  end

  // monitor: pops scoreboard on lower-level events
  initial begin
    logic prevFill = 1'b0;
    logic prevVwb = 1'b0;
    forever begin
      @(negedge clk); #5;
      if (rstN) begin
        if (wbufValid) popCmp(EV_WBUF, wbufAddr);
        if (fillReq && !prevFill) popCmp(EV_FILL, fillAddr);
        if (vwbReq && !prevVwb) popCmp(EV_VWB, vwbAddr);
      end
      prevFill = fillReq;
      prevVwb  = vwbReq;
    end
  end

  task automatic waitIdle();
    #2;
    while (!cpuReady) begin @(negedge clk); #3; end
  endtask

  task automatic access(logic we, logic [31:0] addr, logic expHit, string req);
    @(negedge clk); #1;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr;
    #2;
    chk(req, {31'd0, cpuReady}, 32'd1);
    chk(req, {31'd0, cpuHit}, {31'd0, expHit});
    @(negedge clk); #1;
    cpuReq = 1'b0;
    waitIdle();
  endtask

  task automatic runOp(logic inv, logic [31:0] base, int lines);
    @(negedge clk); #1;
    opReq = 1'b1; opInval = inv; opAddr = base; opLines = 8'(lines);
    @(negedge clk); #1;
    opReq = 1'b0;
    waitIdle();
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #3;
    chk("R3 reset ready", {31'd0, cpuReady}, 32'd1);
    chk("R3 reset fill", {31'd0, fillReq}, 32'd0);
    chk("R3 reset vwb", {31'd0, vwbReq}, 32'd0);

    // R1 R3 R5: first read misses, line address fetched
    expect_ev(EV_FILL, mk(1, 5));
    access(1'b0, mk(1, 5) + 32'h8, 1'b0, "R3 first miss");
    access(1'b0, mk(1, 5) + 32'h3C, 1'b1, "R1 R5 offset hit");

    // R4: write miss forwarded, no allocation
    expect_ev(EV_WBUF, mk(2, 5) + 32'h4);
    access(1'b1, mk(2, 5) + 32'h4, 1'b0, "R4 write miss");
    expect_ev(EV_FILL, mk(2, 5));
    access(1'b0, mk(2, 5), 1'b0, "R4 no alloc");

    // R1 R2: another set, coexistence
    expect_ev(EV_FILL, mk(1, 6));
    access(1'b0, mk(1, 6), 1'b0, "R1 other set");
    access(1'b0, mk(1, 5), 1'b1, "R2 way0 resident");
    access(1'b0, mk(2, 5), 1'b1, "R2 way1 resident");

    // R6 R7: write hit updates LRU, clean victim
    access(1'b1, mk(1, 5), 1'b1, "R6 write hit");
    expect_ev(EV_FILL, mk(3, 5));
    access(1'b0, mk(3, 5), 1'b0, "R7 evict lru");
    access(1'b0, mk(1, 5), 1'b1, "R7 recent kept");
    access(1'b0, mk(3, 5), 1'b1, "R7 new resident");

    // R8: dirty victim written back after fill
    expect_ev(EV_FILL, mk(4, 5));
    expect_ev(EV_VWB, mk(1, 5));
    access(1'b0, mk(4, 5), 1'b0, "R8 dirty victim");

    // R9: noncacheable fill cancels writeback
    access(1'b1, mk(4, 5), 1'b1, "R6 dirty way0");
    access(1'b1, mk(3, 5), 1'b1, "R6 dirty way1");
    nextCacheable = 1'b0;
    expect_ev(EV_FILL, mk(5, 5));
    access(1'b0, mk(5, 5), 1'b0, "R9 nc miss");
    access(1'b0, mk(4, 5), 1'b1, "R9 victim resident");
    expect_ev(EV_FILL, mk(5, 5));
    access(1'b0, mk(5, 5), 1'b0, "R9 not installed");
    nextCacheable = 1'b1;
    access(1'b0, mk(3, 5), 1'b1, "R9 other resident");

    // R12: stall during fill
    fillDelay = 6;
    expect_ev(EV_FILL, mk(7, 9));
    @(negedge clk); #1;
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = mk(7, 9);
    #2;
    chk("R12 miss accept", {31'd0, cpuHit}, 32'd0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
      cpuWe = 1'b1; cpuAddr = mk(8, 9);
      #2;
      chk("R12 not ready", {31'd0, cpuReady}, 32'd0);
      chk("R12 no wbuf", {31'd0, wbufValid}, 32'd0);
      chk("R12 no hit", {31'd0, cpuHit}, 32'd0);
    end
    @(negedge clk); #1;
    cpuReq = 1'b0;
    waitIdle();
    fillDelay = 2;
    access(1'b0, mk(7, 9), 1'b1, "R5 R12 filled");

    // R11: writeback only keeps line valid and clean
    expect_ev(EV_VWB, mk(4, 5));
    runOp(1'b0, mk(4, 4), 3);
    access(1'b0, mk(4, 5), 1'b1, "R11 still valid");
    access(1'b0, mk(3, 5), 1'b1, "R11 touch other");
    expect_ev(EV_FILL, mk(6, 5));
    access(1'b0, mk(6, 5), 1'b0, "R11 clean evict");

    // R10: writeback-invalidate
    expect_ev(EV_FILL, mk(3, 6));
    access(1'b0, mk(3, 6), 1'b0, "R10 setup");
    expect_ev(EV_VWB, mk(3, 5));
    runOp(1'b1, mk(3, 5), 2);
    expect_ev(EV_FILL, mk(3, 5));
    access(1'b0, mk(3, 5), 1'b0, "R10 dirty invalidated");
    expect_ev(EV_FILL, mk(3, 6));
    access(1'b0, mk(3, 6), 1'b0, "R10 clean invalidated");
    access(1'b0, mk(1, 6), 1'b1, "R10 other tag kept");
    access(1'b0, mk(6, 5), 1'b1, "R10 other tag kept");

    // R13: operation priority and empty range
    @(negedge clk); #1;
    opReq = 1'b1; opInval = 1'b1; opAddr = mk(3, 5); opLines = 8'd0;
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = mk(9, 0);
    #2;
    chk("R13 op wins wbuf", {31'd0, wbufValid}, 32'd0);
    chk("R13 op wins hit", {31'd0, cpuHit}, 32'd0);
    @(negedge clk); #1;
    opReq = 1'b0; cpuReq = 1'b0;
    waitIdle();
    access(1'b0, mk(3, 5), 1'b1, "R13 empty range");

    repeat (4) @(negedge clk);
    chk("R5 R8 scoreboard drained", 32'(expQ.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule